// File: doc/BRIEF.md
# Lane-Partitioned Integer Adder

This block adds or subtracts two 32-bit words. A mode input decides how each word is read: as one 32-bit lane, as two 16-bit lanes or as four 8-bit lanes. One datapath built from 8-bit slices serves all three lane widths. The carry between neighbouring slices is either passed on or replaced at a lane head. At a lane head the carry-in becomes the subtract flag. This keeps each lane's arithmetic confined to its own bits, and each lane wraps modulo its own width.

The unit is fully pipelined and has two register stages. The first stage captures the operands, the operation and the mode, with the second operand already inverted for a subtract. The second stage captures the sliced sum. A caller can present a new operation on every clock. Mode and operation travel with their data, so consecutive operations may use different lane widths. An output valid flag marks the cycle in which each result appears. The result register keeps its last value while no new result arrives.

Top module: `psadd_unit`

## Requirements
- R1: With mode 2'b00 or 2'b11 the result is (A + B) mod 2^32 for an add, with carries rippling across the whole word.
- R2: With mode 2'b01 the word holds two 16-bit lanes, bits [15:0] and [31:16]. Each result lane is computed from the same lane of both operands only.
- R3: With mode 2'b10 the word holds four 8-bit lanes at bits [8k+7:8k], k = 0..3. Each result lane is computed from the same lane of both operands only.
- R4: With op_sub_i = 1 each lane yields (A_lane - B_lane) mod 2^width, computed as A_lane + ~B_lane + 1. With op_sub_i = 0 the unit adds.
- R5: No carry or borrow crosses a lane boundary. For example, 0x00FF00FF + 0x00010001 gives 0x00000000 in 8-bit mode, and 0x00000000 - 0x01010101 gives 0xFFFFFFFF in 8-bit mode but 0xFEFEFEFF in 32-bit mode.
- R6: out_valid_o is high exactly two clock cycles after in_valid_i was sampled high. result_o carries that operation's result in the same cycle. out_valid_o is never high one cycle after a lone operation.
- R7: A new operation is accepted on every cycle. Back-to-back operations with different modes and operation codes each produce the result for their own mode and code, in issue order.
- R8: While rst_i (synchronous, active high) is asserted, out_valid_o is 0 and result_o is 0 from the next clock on.
- R9: In any cycle where out_valid_o is low, result_o keeps the value it had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Operation present this cycle |
| op_sub_i | input | 1 | 1 = subtract B from A, 0 = add |
| mode_i | input | 2 | Lane split: 00/11 one 32-bit lane, 01 two 16-bit lanes, 10 four 8-bit lanes |
| opa_i | input | 32 | Operand A, packed lanes |
| opb_i | input | 32 | Operand B, packed lanes |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 32 | Packed result |

## Verification
Three kinds of internal fault show at the ports in different ways. A wrongly chosen lane head shows as a carry or borrow leaking into the next lane, as an off-by-one bit at the bottom of that lane. It appears on the very result whose operands produce a carry at that boundary, which is why the bench uses all-ones bytes and zero-minus-one patterns. A mode or operation code that is not carried along with its data corrupts only the result following a mode change, so back-to-back mixed streams are needed to expose it. A mis-sized valid pipeline moves out_valid_o one cycle off and is caught on the first operation.

// File: rtl/psadd_pkg.sv
package psadd_pkg;

    typedef enum logic [1:0] {
        MODE_WORD     = 2'b00,
        MODE_HALF     = 2'b01,
        MODE_BYTE     = 2'b10,
        MODE_WORD_ALT = 2'b11
    } lane_mode_e;

    typedef struct packed {
        logic       sub;
        lane_mode_e mode;
        logic [31:0] a;
        logic [31:0] b;
    } stage_op_s;

endpackage

// File: rtl/psadd_lane_slice.sv
module psadd_lane_slice #(
    parameter int SLICE_W = 8
) (
    input  logic [SLICE_W-1:0] a_i,
    input  logic [SLICE_W-1:0] b_i,
    input  logic               cin_i,
    output logic [SLICE_W-1:0] sum_o,
    output logic               cout_o
);
    localparam int EXT_W = SLICE_W + 1;

    logic [EXT_W-1:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, a_i} + {1'b0, b_i} + {{SLICE_W{1'b0}}, cin_i};
    end

    assign sum_o  = wide_sum[SLICE_W-1:0];
    assign cout_o = wide_sum[SLICE_W];
endmodule

// File: rtl/psadd_head_map.sv
module psadd_head_map
    import psadd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SLICE_W = 8,
    localparam int NSLICE = DATA_W / SLICE_W
) (
    input  lane_mode_e        mode_i,
    output logic [NSLICE-1:0] head_o
);
    for (genvar i = 0; i < NSLICE; i++) begin : g_head
        localparam bit AT_WORD = ((i * SLICE_W) % 32) == 0;
        localparam bit AT_HALF = ((i * SLICE_W) % 16) == 0;
        localparam bit AT_BYTE = ((i * SLICE_W) % 8) == 0;

        always_comb begin
            unique case (mode_i)
                MODE_HALF: head_o[i] = AT_HALF;
                MODE_BYTE: head_o[i] = AT_BYTE;
                default:   head_o[i] = AT_WORD;
            endcase
        end
    end
endmodule

// File: rtl/psadd_operand_stage.sv
module psadd_operand_stage
    import psadd_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      valid_i,
    input  stage_op_s op_i,
    output logic      valid_o,
    output stage_op_s op_o
);
    stage_op_s conditioned;

    always_comb begin
        conditioned   = op_i;
        conditioned.b = op_i.sub ? ~op_i.b : op_i.b;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_o <= 1'b0;
        end else begin
            valid_o <= valid_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (valid_i) begin
            op_o <= conditioned;
        end
    end
endmodule

// File: rtl/psadd_unit.sv
module psadd_unit
    import psadd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SLICE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              in_valid_i,
    input  logic              op_sub_i,
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] result_o
);
    localparam int NSLICE = DATA_W / SLICE_W;

    stage_op_s         in_op;
    stage_op_s         s1_op;
    logic              s1_valid;
    logic [NSLICE-1:0] lane_head;
    logic [NSLICE-1:0] slice_cin;
    logic [NSLICE-1:0] slice_cout;
    logic [DATA_W-1:0] raw_sum;
    logic              top_carry_unused;

    always_comb begin
        in_op.sub  = op_sub_i;
        in_op.mode = lane_mode_e'(mode_i);
        in_op.a    = opa_i;
        in_op.b    = opb_i;
    end

    psadd_operand_stage u_stage1 (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .valid_i (in_valid_i),
        .op_i    (in_op),
        .valid_o (s1_valid),
        .op_o    (s1_op)
    );

    psadd_head_map #(
        .DATA_W  (DATA_W),
        .SLICE_W (SLICE_W)
    ) u_heads (
        .mode_i (s1_op.mode),
        .head_o (lane_head)
    );

    for (genvar i = 0; i < NSLICE; i++) begin : g_slice
        if (i == 0) begin : g_first
            assign slice_cin[i] = s1_op.sub;
        end else begin : g_rest
            assign slice_cin[i] = lane_head[i] ? s1_op.sub : slice_cout[i-1];
        end

        psadd_lane_slice #(
            .SLICE_W (SLICE_W)
        ) u_slice (
            .a_i    (s1_op.a[i*SLICE_W +: SLICE_W]),
            .b_i    (s1_op.b[i*SLICE_W +: SLICE_W]),
            .cin_i  (slice_cin[i]),
            .sum_o  (raw_sum[i*SLICE_W +: SLICE_W]),
            .cout_o (slice_cout[i])
        );
    end

    assign top_carry_unused = slice_cout[NSLICE-1];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_valid_o <= 1'b0;
            result_o    <= '0;
        end else begin
            out_valid_o <= s1_valid;
            if (s1_valid) begin
                result_o <= raw_sum;
            end
        end
    end
endmodule

// File: rtl/psadd_unit_chk.sv
module psadd_unit_chk (
    input logic        clk_i,
    input logic        rst_i,
    input logic        in_valid_i,
    input logic        op_sub_i,
    input logic [1:0]  mode_i,
    input logic [31:0] opa_i,
    input logic [31:0] opb_i,
    input logic        out_valid_o,
    input logic [31:0] result_o
);
    logic [1:0] warm;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            warm <= 2'd0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        rst_i |=> (!out_valid_o && result_o == 32'h0)); // R8

    AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
        (warm >= 2'd2) |-> (out_valid_o == $past(in_valid_i, 2))); // R6

    AST_WORD_ADD: assert property (@(posedge clk_i) disable iff (rst_i)
        (warm >= 2'd2 && out_valid_o && !$past(op_sub_i, 2)
         && ($past(mode_i, 2) == 2'b00 || $past(mode_i, 2) == 2'b11))
        |-> (result_o == $past(opa_i, 2) + $past(opb_i, 2))); // R1

    AST_HALF_SUB: assert property (@(posedge clk_i) disable iff (rst_i)
        (warm >= 2'd2 && out_valid_o && $past(op_sub_i, 2) && $past(mode_i, 2) == 2'b01)
        |-> (result_o[31:16] == $past(opa_i[31:16], 2) - $past(opb_i[31:16], 2)
             && result_o[15:0] == $past(opa_i[15:0], 2) - $past(opb_i[15:0], 2))); // R4

    AST_BYTE_ISOLATED: assert property (@(posedge clk_i) disable iff (rst_i)
        (warm >= 2'd2 && out_valid_o && !$past(op_sub_i, 2) && $past(mode_i, 2) == 2'b10)
        |-> (result_o[15:8] == $past(opa_i[15:8], 2) + $past(opb_i[15:8], 2)
             && result_o[31:24] == $past(opa_i[31:24], 2) + $past(opb_i[31:24], 2))); // R5

    AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (warm >= 2'd1 && !out_valid_o) |-> $stable(result_o)); // R9
endmodule

bind psadd_unit psadd_unit_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .in_valid_i  (in_valid_i),
    .op_sub_i    (op_sub_i),
    .mode_i      (mode_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .out_valid_o (out_valid_o),
    .result_o    (result_o)
);

// File: tb/psadd_unit_tb_top.sv
`timescale 1ns/1ps
module psadd_unit_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        in_valid_i = 1'b0;
    logic        op_sub_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        out_valid_o;
    logic [31:0] result_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] sa [256];
    logic [31:0] sb [256];
    logic        ss [256];
    logic [1:0]  sm [256];

    always #5 clk_i = ~clk_i;

    psadd_unit dut_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .in_valid_i  (in_valid_i),
        .op_sub_i    (op_sub_i),
        .mode_i      (mode_i),
        .opa_i       (opa_i),
        .opb_i       (opb_i),
        .out_valid_o (out_valid_o),
        .result_o    (result_o)
    );

    function automatic logic [31:0] ref_calc(logic [31:0] a, logic [31:0] b,
                                             logic sub, logic [1:0] mode);
        int w;
        logic [31:0] mask;
        logic [31:0] r;
        w    = (mode == 2'b01) ? 16 : (mode == 2'b10) ? 8 : 32;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        r    = '0;
        for (int l = 0; l < 32 / w; l++) begin
            logic [31:0] la, lb, lr;
            la = (a >> (l * w)) & mask;
            lb = (b >> (l * w)) & mask;
            lr = sub ? (la - lb) : (la + lb);
            r  = r | ((lr & mask) << (l * w));
        end
        return r;
    endfunction

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [31:0] a, logic [31:0] b, logic sub, logic [1:0] mode);
        in_valid_i = 1'b1;
        opa_i      = a;
        opb_i      = b;
        op_sub_i   = sub;
        mode_i     = mode;
    endtask

    task automatic idle();
        in_valid_i = 1'b0;
        opa_i      = $urandom;
        opb_i      = $urandom;
    endtask

    // R8: outputs quiet under reset
    task automatic t_reset();
        rst_i = 1'b1;
        repeat (3) @(negedge clk_i);
        check32("R8 valid", {31'b0, out_valid_o}, 32'h0);
        check32("R8 result", result_o, 32'h0);
        rst_i = 1'b0;
    endtask

    // R6 plus one data check for a lone operation
    task automatic t_single(string req, logic [31:0] a, logic [31:0] b,
                            logic sub, logic [1:0] mode, logic [31:0] exp);
        @(negedge clk_i);
        drive(a, b, sub, mode);
        @(negedge clk_i);
        idle();
        check32("R6 early", {31'b0, out_valid_o}, 32'h0);
        @(negedge clk_i);
        check32("R6 valid", {31'b0, out_valid_o}, 32'h1);
        check32(req, result_o, exp);
    endtask

    // R9: result holds while idle
    task automatic t_hold();
        logic [31:0] kept;
        t_single("R9 setup", 32'h1111_2222, 32'h0101_0101, 1'b0, 2'b00, 32'h1212_2323);
        kept = result_o;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk_i);
            check32("R9 idle valid", {31'b0, out_valid_o}, 32'h0);
            check32("R9 hold", result_o, kept);
        end
    endtask

    // R7: back-to-back stream from the sa/sb/ss/sm arrays
    task automatic t_stream(string req, int n);
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk_i);
            if (i >= 2) begin
                check32({req, " valid"}, {31'b0, out_valid_o}, 32'h1);
                check32(req, result_o, ref_calc(sa[i-2], sb[i-2], ss[i-2], sm[i-2]));
            end
            if (i < n) drive(sa[i], sb[i], ss[i], sm[i]);
            else idle();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single("R1 wrap",     32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 2'b00, 32'h0000_0000);
        t_single("R1 alt mode", 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 2'b11, 32'h8000_0000);
        t_single("R2 halves",   32'h1234_FFFF, 32'h0001_0001, 1'b0, 2'b01, 32'h1235_0000);
        t_single("R3 bytes",    32'h0102_0304, 32'h1020_3040, 1'b0, 2'b10, 32'h1122_3344);
        t_single("R4 half sub", 32'h0005_0003, 32'h0002_0005, 1'b1, 2'b01, 32'h0003_FFFE);
        t_single("R4 word sub", 32'h0000_0000, 32'h0101_0101, 1'b1, 2'b00, 32'hFEFE_FEFF);
        t_single("R5 byte carry", 32'h00FF_00FF, 32'h0001_0001, 1'b0, 2'b10, 32'h0000_0000);
        t_single("R5 half carry", 32'h00FF_00FF, 32'h0001_0001, 1'b0, 2'b01, 32'h0100_0100);
        t_single("R5 byte borrow", 32'h0000_0000, 32'h0101_0101, 1'b1, 2'b10, 32'hFFFF_FFFF);
        t_hold();

        // R7 directed: mode and op change on every cycle
        for (int i = 0; i < 8; i++) begin
            sa[i] = 32'h80FF_7F01 + i;
            sb[i] = 32'h8001_0181;
            ss[i] = i[0];
            sm[i] = 2'(i % 4);
        end
        t_stream("R7 mixed", 8);

        // R7 random stream across all modes
        for (int i = 0; i < 200; i++) begin
            sa[i] = $urandom;
            sb[i] = $urandom;
            ss[i] = 1'($urandom);
            sm[i] = 2'($urandom);
        end
        t_stream("R7 random", 200);

        t_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule